// File: doc/BRIEF.md
# Byte-Stream Matrix Multiply Protocol Controller

This block sits between a byte-wide serial receiver/transmitter pair and a sequential matrix multiply engine. It stays idle until the command byte 0x01 arrives. It then builds 16-bit operands from pairs of incoming bytes and writes the first matrix and then the second into the engine through a load port. After the last operand is written it starts the engine and waits for the engine's done indication.

When the engine is done, the controller reads back the N×N product one word at a time through a synchronous read port. It sends each 32-bit word as four bytes, least significant byte first, and sends the words in ascending index order. A 32-bit compute cycle count, taken from the engine when it reports done, follows as four more bytes. The controller then returns to idle. The matrix dimension N is a parameter shared with the engine and takes the values 4, 8 or 16. Bit-level serial timing and the arithmetic belong to the neighbouring blocks.

Top module: `mmproto_ctrl`

## Requirements
- R1: While reset is applied and after it is released, tx_valid, ld_en, go and rd_en are all low until a command is received.
- R2: In idle, any received byte other than 0x01 is dropped: it causes no load write and no transmit byte, and the controller stays idle.
- R3: After 0x01, the next 2·N·N bytes form N·N first-matrix words. Word k is {byte 2k+1, byte 2k}, so the low byte comes first. Each word is written with ld_sel=0 and ld_addr=k, where k = row·N + column. Each write is a single ld_en cycle, in the cycle after the word's high byte is received.
- R4: The following 2·N·N bytes form the second matrix, packed the same way and written with ld_sel=1 and ld_addr=k.
- R5: go is a one-cycle pulse, asserted once per transaction. It comes in the cycle after the final second-matrix write, and never together with ld_en.
- R6: Between go and eng_done the controller issues no rd_en and no transmit byte.
- R7: After done, for k = 0 to N·N−1 in turn, the controller asserts rd_en with rd_addr=k. It takes rd_data in the following cycle and sends it as four bytes, least significant first, before reading the next word.
- R8: After the last result byte, the controller sends the value that was on cyc_count in the cycle eng_done was high, as four bytes, least significant first.
- R9: A byte is transferred on a clock edge where tx_valid and tx_ready are both high. While tx_valid is high and tx_ready is low, tx_valid and tx_byte hold their values.
- R10: After the last cycle-count byte, the controller returns to idle, and a new 0x01 starts a complete new transaction.
- R11: Bytes received after the final second-matrix byte and before the return to idle, 0x01 included, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_byte | output | 8 | Transmit byte |
| ld_en | output | 1 | Operand write strobe |
| ld_sel | output | 1 | 0 = first matrix, 1 = second matrix |
| ld_addr | output | log2(N·N) | Row-major operand index |
| ld_data | output | 16 | Signed operand |
| go | output | 1 | Engine start pulse |
| eng_done | input | 1 | Engine finished |
| cyc_count | input | 32 | Engine compute cycle count |
| rd_en | output | 1 | Result read request |
| rd_addr | output | log2(N·N) | Row-major result index |
| rd_data | input | 32 | Result word, valid the cycle after rd_en |

## Verification
The bench sends junk bytes in idle, to catch a controller that leaves idle or counts the junk as an operand byte, which would shift every later write. It sends stray 0x01 bytes while the engine runs, to catch a controller that restarts in the middle of a transaction. It stalls tx_ready in several patterns, which exposes a controller that drops or changes a byte when the transmitter is not ready. It uses operands with both halves distinct and extreme signed values, which exposes swapped byte order, an operand written one cycle early, and a start pulse issued before the last write. It runs back-to-back transactions, which shows whether the controller really returns to idle.

// File: rtl/mmproto_pkg.sv
package mmproto_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GO,
    ST_WAIT,
    ST_FETCH,
    ST_LATCH,
    ST_SEND,
    ST_CLOAD,
    ST_CSEND
  } mmp_state_e;
endpackage

// File: rtl/mmproto_asm.sv
// Packs little-endian byte groups into operands and drives the load port.
module mmproto_asm #(
  parameter int NN = 16,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          ld_en,
  output logic          ld_sel,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          last
);
  localparam int IB  = DW / 8;
  localparam int BW  = (IB > 1) ? $clog2(IB) : 1;
  localparam int TOT = 2 * NN;
  localparam logic [AW+1:0] TOT_W  = (AW+2)'(TOT);
  localparam logic [AW+1:0] LAST_W = (AW+2)'(TOT - 1);
  localparam logic [BW-1:0] BEND   = BW'(IB - 1);

  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] bi_q, bi_d;
  logic [AW+1:0] wi_q, wi_d;
  logic          en_q, en_d;
  logic          sel_q, sel_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          last_q, last_d;
  logic          full, take, word_end;
  logic [DW-1:0] sh_next;

  assign full     = (wi_q == TOT_W);
  assign take     = en && rx_valid && !full;
  assign word_end = take && (bi_q == BEND);
  assign sh_next  = {rx_byte, sh_q[DW-1:8]};

  always_comb begin
    sh_d   = sh_q;
    bi_d   = bi_q;
    wi_d   = wi_q;
    en_d   = 1'b0;
    sel_d  = sel_q;
    addr_d = addr_q;
    dat_d  = dat_q;
    last_d = 1'b0;
    if (clr) begin
      bi_d = '0;
      wi_d = '0;
    end else if (take) begin
      sh_d = sh_next;
      if (word_end) begin
        bi_d   = '0;
        wi_d   = wi_q + 1'b1;
        en_d   = 1'b1;
        sel_d  = wi_q[AW];
        addr_d = wi_q[AW-1:0];
        dat_d  = sh_next;
        last_d = (wi_q == LAST_W);
      end else begin
        bi_d = bi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bi_q   <= '0;
      wi_q   <= '0;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      addr_q <= '0;
      dat_q  <= '0;
      last_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      last_q <= last_d;
      bi_q   <= bi_d;
      wi_q   <= wi_d;
      if (take) sh_q <= sh_d;
      if (word_end) begin
        sel_q  <= sel_d;
        addr_q <= addr_d;
        dat_q  <= dat_d;
      end
    end
  end

  assign ld_en   = en_q;
  assign ld_sel  = sel_q;
  assign ld_addr = addr_q;
  assign ld_data = dat_q;
  assign last    = last_q;
endmodule

// File: rtl/mmproto_ser.sv
// Sends one word as bytes, least significant first, with a valid/ready handshake.
module mmproto_ser #(
  parameter int WB = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WB-1:0] word,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          fin
);
  localparam int NB = WB / 8;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [CW-1:0] CEND = CW'(NB - 1);

  logic [WB-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          fire;

  assign fire = act_q && tx_ready;
  assign fin  = fire && (cnt_q == CEND);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      sh_d  = word;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (fire) begin
      sh_d = sh_q >> 8;
      if (fin) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
      if (load || fire) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign tx_valid = act_q;
  assign tx_byte  = sh_q[7:0];
endmodule

// File: rtl/mmproto_ctrl.sv
// Protocol sequencer: command, operand load, start, wait, result stream.
module mmproto_ctrl
  import mmproto_pkg::*;
#(
  parameter int          N   = 4,
  parameter int          DW  = 16,
  parameter int          RW  = 32,
  parameter logic [7:0]  CMD = 8'h01,
  localparam int         NN  = N * N,
  localparam int         AW  = $clog2(NN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic          ld_en,
  output logic          ld_sel,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          go,
  input  logic          eng_done,
  input  logic [RW-1:0] cyc_count,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [RW-1:0] rd_data
);
  localparam logic [AW-1:0] IDX_END = AW'(NN - 1);

  logic [1:0]    rs_q;
  logic          rst_ni;
  mmp_state_e    st_q, st_d;
  logic [AW-1:0] ridx_q, ridx_d;
  logic [RW-1:0] cnt_q;
  logic          cnt_en;
  logic          asm_clr, asm_en, asm_last;
  logic          ser_load, ser_fin;
  logic [RW-1:0] ser_word;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign asm_en = (st_q == ST_LOAD);

  mmproto_asm #(.NN(NN), .AW(AW), .DW(DW)) u_asm (
    .clk     (clk),
    .rst_n   (rst_ni),
    .clr     (asm_clr),
    .en      (asm_en),
    .rx_valid(rx_valid),
    .rx_byte (rx_byte),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .last    (asm_last)
  );

  mmproto_ser #(.WB(RW)) u_ser (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load    (ser_load),
    .word    (ser_word),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid),
    .tx_byte (tx_byte),
    .fin     (ser_fin)
  );

  always_comb begin
    st_d     = st_q;
    ridx_d   = ridx_q;
    cnt_en   = 1'b0;
    asm_clr  = 1'b0;
    go       = 1'b0;
    rd_en    = 1'b0;
    ser_load = 1'b0;
    ser_word = rd_data;
    case (st_q)
      ST_IDLE: begin
        asm_clr = 1'b1;
        if (rx_valid && (rx_byte == CMD)) st_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (asm_last) st_d = ST_GO;
      end
      ST_GO: begin
        go   = 1'b1;
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (eng_done) begin
          cnt_en = 1'b1;
          ridx_d = '0;
          st_d   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        rd_en = 1'b1;
        st_d  = ST_LATCH;
      end
      ST_LATCH: begin
        ser_load = 1'b1;
        st_d     = ST_SEND;
      end
      ST_SEND: begin
        if (ser_fin) begin
          if (ridx_q == IDX_END) begin
            st_d = ST_CLOAD;
          end else begin
            ridx_d = ridx_q + 1'b1;
            st_d   = ST_FETCH;
          end
        end
      end
      ST_CLOAD: begin
        ser_load = 1'b1;
        ser_word = cnt_q;
        st_d     = ST_CSEND;
      end
      ST_CSEND: begin
        if (ser_fin) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ridx_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      ridx_q <= ridx_d;
      if (cnt_en) cnt_q <= cyc_count;
    end
  end

  assign rd_addr = ridx_q;
endmodule

// File: rtl/mmproto_chk.sv
module mmproto_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       ld_en,
  input logic       rd_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte
);
  a_r5_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

  a_r5_go_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!ld_en && $past(ld_en)));

  a_r6_quiet_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!tx_valid && !rd_en));

  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  a_r7_read_between_words: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !tx_valid);

  a_r11_no_load_in_output: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> (!tx_valid && !rd_en && !go));
endmodule

bind mmproto_ctrl mmproto_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go),
  .ld_en   (ld_en),
  .rd_en   (rd_en),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .tx_byte (tx_byte)
);

// File: tb/mmproto_ctrl_tb.sv
module mmproto_ctrl_tb;
  localparam int N   = 4;
  localparam int NN  = N * N;
  localparam int AW  = $clog2(NN);
  localparam int LAT = 30;

  logic          clk;
  logic          rst_n;
  logic          rx_valid;
  logic [7:0]    rx_byte;
  logic          tx_ready;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          ld_en;
  logic          ld_sel;
  logic [AW-1:0] ld_addr;
  logic [15:0]   ld_data;
  logic          go;
  logic          eng_done;
  logic [31:0]   cyc_count;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;

  mmproto_ctrl #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .go(go), .eng_done(eng_done), .cyc_count(cyc_count),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;
  int mode = 0;
  int cyc = 0;
  int go_cnt = 0;
  int ld_total = 0;
  int exp_rd = 0;
  bit hold_pend = 1'b0;
  logic [7:0] held;
  int amat [NN];
  int bmat [NN];
  int cmat [NN];
  int ld_q [$];
  logic [7:0] tx_q [$];
  logic [31:0] cval_cur;
  bit eng_busy;
  int eng_lat;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural engine: synchronous read, done after a fixed latency.
  always @(posedge clk) begin
    if (!rst_n) begin
      eng_done <= 1'b0;
      eng_busy <= 1'b0;
      eng_lat  <= 0;
      rd_data  <= '0;
    end else begin
      eng_done <= 1'b0;
      if (go) begin
        eng_busy <= 1'b1;
        eng_lat  <= LAT;
      end else if (eng_busy) begin
        if (eng_lat == 0) begin
          eng_done <= 1'b1;
          eng_busy <= 1'b0;
        end else begin
          eng_lat <= eng_lat - 1;
        end
      end
      if (rd_en) rd_data <= cmat[rd_addr];
    end
  end

  // Reference comparison, every clock, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    case (mode)
      0: tx_ready = 1'b1;
      1: tx_ready = (cyc % 2) == 0;
      default: tx_ready = (cyc % 5) > 2;
    endcase
    if (!rst_n) tx_ready = 1'b0;
    if (mon_on && rst_n) begin
      if (hold_pend)
        chk(tx_valid && (tx_byte == held), "R9 hold", {tx_valid, tx_byte}, {1'b1, held});
      if (tx_valid && tx_ready) begin
        if (tx_q.size() == 0) begin
          chk(1'b0, "R10 unexpected tx byte", tx_byte, 0);
        end else begin
          logic [7:0] e;
          bit is_cnt;
          is_cnt = (tx_q.size() <= 4);
          e = tx_q.pop_front();
          chk(tx_byte == e, is_cnt ? "R8 count byte" : "R7 result byte", tx_byte, e);
        end
      end
      hold_pend = tx_valid && !tx_ready;
      held = tx_byte;
      if (ld_en) begin
        int act;
        act = (int'(ld_sel) << 24) | (int'(8'(ld_addr)) << 16) | int'(ld_data);
        if (ld_q.size() == 0) begin
          chk(1'b0, "R2/R11 unexpected load", act, 0);
        end else begin
          int e;
          e = ld_q.pop_front();
          chk(act == e, ld_sel ? "R4 second matrix write" : "R3 first matrix write", act, e);
          if (e[24]) bmat[e[23:16]] = int'($signed(e[15:0]));
          else       amat[e[23:16]] = int'($signed(e[15:0]));
        end
        ld_total++;
      end
      if (go) begin
        go_cnt++;
        chk(ld_q.size() == 0 && !ld_en, "R5 start after last write", ld_q.size(), 0);
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            int s;
            s = 0;
            for (int k = 0; k < N; k++) s += amat[i*N+k] * bmat[k*N+j];
            cmat[i*N+j] = s;
          end
        tx_q.delete();
        for (int k = 0; k < NN; k++)
          for (int b = 0; b < 4; b++) tx_q.push_back(8'(cmat[k] >>> (8*b)));
        for (int b = 0; b < 4; b++) tx_q.push_back(8'(cval_cur >> (8*b)));
        exp_rd = 0;
      end
      if (eng_busy && (tx_valid || rd_en))
        chk(1'b0, "R6 activity before done", {tx_valid, rd_en}, 0);
      if (rd_en) begin
        chk(int'(rd_addr) == exp_rd, "R7 read order", rd_addr, exp_rd);
        exp_rd++;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic int opa(input int kind, input int k);
    case (kind)
      0: return (k % (N + 1) == 0) ? 1 : 0;
      1: return -32768;
      default: return 32767 - k * 1234;
    endcase
  endfunction

  function automatic int opb(input int kind, input int k);
    case (kind)
      0: return k * 37 - 200;
      1: return -32768;
      default: return ((k * 7919 + 4660) % 65536) - 32768;
    endcase
  endfunction

  task automatic run_txn(input int kind, input int m, input logic [31:0] cv,
                         input bit strays, input int gap);
    int go_before;
    go_before = go_cnt;
    @(posedge clk);
    mode = m;
    cval_cur = cv;
    @(negedge clk);
    cyc_count = cv;
    for (int k = 0; k < NN; k++)
      ld_q.push_back((0 << 24) | (k << 16) | (opa(kind, k) & 32'hFFFF));
    for (int k = 0; k < NN; k++)
      ld_q.push_back((1 << 24) | (k << 16) | (opb(kind, k) & 32'hFFFF));
    send_byte(8'h01, gap);
    for (int k = 0; k < NN; k++) begin
      logic [15:0] v;
      v = 16'(opa(kind, k));
      send_byte(v[7:0], gap);
      send_byte(v[15:8], gap);
    end
    for (int k = 0; k < NN; k++) begin
      logic [15:0] v;
      v = 16'(opb(kind, k));
      send_byte(v[7:0], gap);
      send_byte(v[15:8], gap);
    end
    if (strays) begin
      repeat (4) @(negedge clk);
      send_byte(8'h01, 0);
      send_byte(8'h01, 1);
      send_byte(8'h7E, 0);
    end
    while (go_cnt == go_before) @(negedge clk);
    chk(go_cnt == go_before + 1, "R5 single start", go_cnt - go_before, 1);
    while (tx_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(!tx_valid && !rd_en && !go, "R10 back to idle", {tx_valid, rd_en, go}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int ld_before;
    rst_n = 1'b0;
    rx_valid = 1'b0;
    rx_byte = '0;
    cyc_count = '0;
    cval_cur = '0;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !ld_en && !go && !rd_en, "R1 reset outputs",
        {tx_valid, ld_en, go, rd_en}, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (5) @(negedge clk);
    chk(!tx_valid && !ld_en && !go && !rd_en, "R1 after release",
        {tx_valid, ld_en, go, rd_en}, 0);

    run_txn(0, 0, 32'h0000_0054, 1'b0, 0);
    run_txn(1, 1, 32'hDEAD_BEEF, 1'b1, 1);

    ld_before = ld_total;
    send_byte(8'h00, 0);
    send_byte(8'h02, 1);
    send_byte(8'hFF, 0);
    send_byte(8'h81, 0);
    send_byte(8'h10, 2);
    repeat (4) @(negedge clk);
    chk(ld_total == ld_before && !tx_valid, "R2 junk in idle", ld_total - ld_before, 0);

    run_txn(2, 2, 32'h1234_5678, 1'b1, 0);
    run_txn(0, 2, 32'h8000_0001, 1'b0, 2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule